// File: doc/BRIEF.md
# Reference Clock Divider with Ratio Lock Handshake

The block divides a reference clock by a programmable ratio and produces the result as a single-cycle clock-enable pulse. Software controls it through one 32-bit control word. It stages a new ratio in the word, then writes the apply strobe. The strobe reloads the divider and drops a lock status bit. The lock bit rises again once the divider has completed one full period at the new ratio, so software confirms the change by polling for lock. The same word also holds an output enable, a reset for the divided domain, and a gate for the buffered reference output.

Two build variants exist. In the gated variant the ratio can only be changed while the output is disabled. Any attempt to change it while enabled is refused and clears the enable. In the on-the-fly variant there is no enable. A ratio can be staged at any time while the divider runs, and it takes over at the next apply strobe. A build option can remap forbidden low ratios as they are written. With it, ratio 1 alone becomes 0, or ratios 1 and 2 become 0 and ratio 3 becomes 4.

Top module: `refdiv_ctrl`

## Requirements
- R1: After reset the control word reads all zeros, ref_pass_o is 1 and dom_rst_o is 0. The lock bit becomes 1 one cycle after reset is released.
- R2: The control word holds the enable at bit 0, the domain reset at bit 1, the ratio field at bits 4 upward (RATIO_W bits wide) and the buffer gate at bit 28. Each reads back as written, subject to R10 and R12.
- R3: The apply strobe at bit 2 acts only in the cycle it is written and always reads back as 0.
- R4: A ratio field of 0 or 1 gives a ce_out pulse on every cycle.
- R5: A ratio N of 2 or more gives a ce_out pulse lasting one cycle, once every N cycles.
- R6: The lock bit reads 0 from the clock edge that accepts an apply strobe. It reads 1 again exactly max(N,1) cycles later, which is within 4 × max(N,1) cycles.
- R7: The lock bit sits at bit 31 when LOCK_ALT is 0 and at bit 27 when LOCK_ALT is 1. The unused position reads 0.
- R8: Writing 1 to bit 28 drives ref_pass_o to 0 from the next cycle. Writing 0 drives it to 1.
- R9: While the domain reset bit is 1, dom_rst_o is 1, ce_out stays 0 and the lock bit is cleared.
- R10: In the gated variant, ce_out pulses only while the enable bit is 1. A write while enabled whose ratio differs from the held ratio leaves the ratio unchanged and clears the enable.
- R11: In the on-the-fly variant the enable bit has no effect and reads 0. A written ratio is held but the divider keeps its old period until the next apply strobe.
- R12: With the remap option that forbids ratios 1 to 3, writing 1 or 2 stores 0 and writing 3 stores 4. All other values are stored unchanged.
- R13: When an apply strobe arrives on the same edge as the end of a divider period, the apply wins. The count restarts from zero, the lock bit goes to 0, and the next pulse follows a full new period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word value to write |
| rd_data | output | 32 | Control word readback, including lock status |
| ce_out | output | 1 | Divided clock as a one-cycle enable pulse |
| ref_pass_o | output | 1 | 1 while the buffered reference output is passed |
| dom_rst_o | output | 1 | Reset request for the divided clock domain |

## Verification
Two events can fall on the same edge: an apply strobe and the wrap of the divider counter at the end of a period. The bench provokes this by waiting until ce_out is high at the falling edge and then writing the apply strobe, so that it is sampled on the wrap edge. It then checks three things: that the lock bit reads 0, that no stale lock is taken from the finished period, and that the next pulse arrives after a full period counted from zero. A second collision covers the gated variant. A ratio write arrives while the output is enabled, and the bench checks that the enable clears and the old ratio remains.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    typedef enum logic [1:0] {
        SKIP_NONE = 2'd0,
        SKIP_ONE  = 2'd1,
        SKIP_LOW3 = 2'd2
    } skip_e;

    localparam int EN_POS      = 0;
    localparam int DRST_POS    = 1;
    localparam int APPLY_POS   = 2;
    localparam int RATIO_POS   = 4;
    localparam int BUFGATE_POS = 28;
    localparam int LOCK_MAIN   = 31;
    localparam int LOCK_ALT    = 27;

    // Remap forbidden low ratios at write time.
    function automatic int unsigned remap_ratio(input int unsigned r, input skip_e m);
        int unsigned res;
        res = r;
        case (m)
            SKIP_ONE: begin
                if (r == 1) res = 0;
            end
            SKIP_LOW3: begin
                if (r == 1 || r == 2) res = 0;
                else if (r == 3) res = 4;
            end
            default: res = r;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/refdiv_regs.sv
module refdiv_regs
    import refdiv_pkg::*;
#(
    parameter int    RATIO_W   = 8,
    parameter bit    GATED     = 1'b1,
    parameter skip_e SKIP_MODE = SKIP_NONE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [31:0]        wr_data,
    output logic               en_o,
    output logic               drst_o,
    output logic               gate_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic [RATIO_W-1:0] ratio_next_o,
    output logic               apply_o
);

    localparam logic [31:0] FIELD_ONES = (32'd1 << RATIO_W) - 32'd1;
    localparam logic [31:0] USED_MASK  = (32'd1 << EN_POS) | (32'd1 << DRST_POS)
                                       | (32'd1 << APPLY_POS) | (32'd1 << BUFGATE_POS)
                                       | (FIELD_ONES << RATIO_POS);

    typedef struct packed {
        logic               en;
        logic               drst;
        logic               gate;
        logic [RATIO_W-1:0] ratio;
    } ctl_t;

    ctl_t               s_d, s_q;
    logic [RATIO_W-1:0] req_ratio_d;
    logic               unused_bits;

    assign unused_bits = ^(wr_data & ~USED_MASK);

    always_comb begin
        req_ratio_d = RATIO_W'(remap_ratio(32'(wr_data[RATIO_POS +: RATIO_W]), SKIP_MODE));
        s_d = s_q;
        if (wr_en) begin
            s_d.drst = wr_data[DRST_POS];
            s_d.gate = wr_data[BUFGATE_POS];
            if (GATED) begin
                // Ratio may only move while the output is disabled.
                if (s_q.en && (req_ratio_d != s_q.ratio)) begin
                    s_d.en = 1'b0;
                end else begin
                    s_d.en    = wr_data[EN_POS];
                    s_d.ratio = req_ratio_d;
                end
            end else begin
                s_d.en    = 1'b0;
                s_d.ratio = req_ratio_d;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign en_o         = s_q.en;
    assign drst_o       = s_q.drst;
    assign gate_o       = s_q.gate;
    assign ratio_o      = s_q.ratio;
    assign ratio_next_o = s_d.ratio;
    assign apply_o      = wr_en & wr_data[APPLY_POS];

endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               apply_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               hold_i,
    output logic               tick_o,
    output logic               lock_o,
    output logic [RATIO_W-1:0] act_o
);

    localparam logic [RATIO_W-1:0] TWO = RATIO_W'(2);

    typedef struct packed {
        logic [RATIO_W-1:0] act;
        logic [RATIO_W-1:0] cnt;
        logic               lock;
    } div_t;

    div_t               s_d, s_q;
    logic [RATIO_W-1:0] last_d;

    always_comb begin
        last_d = (s_q.act < TWO) ? '0 : s_q.act - RATIO_W'(1);
        tick_o = !hold_i && (s_q.cnt == last_d);
        s_d    = s_q;
        if (apply_i) begin
            s_d.act  = ratio_i;
            s_d.cnt  = '0;
            s_d.lock = 1'b0;
        end else if (hold_i) begin
            s_d.cnt  = '0;
            s_d.lock = 1'b0;
        end else if (tick_o) begin
            s_d.cnt  = '0;
            s_d.lock = 1'b1;
        end else begin
            s_d.cnt  = s_q.cnt + RATIO_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lock_o = s_q.lock;
    assign act_o  = s_q.act;

endmodule

// File: rtl/refdiv_ctrl.sv
// RATIO_W must lie in 3..23 so the field stays below the lock positions.
module refdiv_ctrl
    import refdiv_pkg::*;
#(
    parameter int    RATIO_W   = 8,
    parameter bit    GATED     = 1'b1,
    parameter skip_e SKIP_MODE = SKIP_NONE,
    parameter bit    LOCK_ALT  = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        ce_out,
    output logic        ref_pass_o,
    output logic        dom_rst_o
);

    localparam int LOCK_BIT = LOCK_ALT ? refdiv_pkg::LOCK_ALT : LOCK_MAIN;

    logic               en, drst, gate, apply, tick, lock;
    logic [RATIO_W-1:0] ratio, ratio_next, act_ratio;

    refdiv_regs #(
        .RATIO_W  (RATIO_W),
        .GATED    (GATED),
        .SKIP_MODE(SKIP_MODE)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .en_o        (en),
        .drst_o      (drst),
        .gate_o      (gate),
        .ratio_o     (ratio),
        .ratio_next_o(ratio_next),
        .apply_o     (apply)
    );

    refdiv_counter #(
        .RATIO_W(RATIO_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .apply_i(apply),
        .ratio_i(ratio_next),
        .hold_i (drst),
        .tick_o (tick),
        .lock_o (lock),
        .act_o  (act_ratio)
    );

    generate
        if (GATED) begin : g_gated
            assign ce_out = tick & en;
        end else begin : g_free
            assign ce_out = tick;
        end
    endgenerate

    always_comb begin
        rd_data                        = '0;
        rd_data[EN_POS]                = en;
        rd_data[DRST_POS]              = drst;
        rd_data[RATIO_POS +: RATIO_W]  = ratio;
        rd_data[BUFGATE_POS]           = gate;
        rd_data[LOCK_BIT]              = lock;
    end

    assign ref_pass_o = ~gate;
    assign dom_rst_o  = drst;

endmodule

// File: rtl/refdiv_ctrl_chk.sv
module refdiv_ctrl_chk #(
    parameter int RATIO_W  = 8,
    parameter bit GATED    = 1'b1,
    parameter int LOCK_BIT = 31
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [31:0]        wr_data,
    input logic [31:0]        rd_data,
    input logic               ce_out,
    input logic               ref_pass_o,
    input logic               dom_rst_o,
    input logic               tick,
    input logic [RATIO_W-1:0] act_ratio
);

    a_r6_lock_low_after_apply: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[2]) |=> !rd_data[LOCK_BIT]);

    a_r6_lock_rises_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[LOCK_BIT]) |-> $past(tick));

    a_r5_single_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_out && act_ratio > RATIO_W'(1) && !(wr_en && wr_data[2])) |=> !ce_out);

    a_r8_buffer_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ref_pass_o != $past(wr_data[28])));

    a_r9_hold_blocks_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dom_rst_o |-> !ce_out);

    generate
        if (GATED) begin : g_gated_chk
            a_r10_no_pulse_disabled: assert property (@(posedge clk) disable iff (!rst_n)
                !rd_data[0] |-> !ce_out);
        end
    endgenerate

endmodule

bind refdiv_ctrl refdiv_ctrl_chk #(
    .RATIO_W (RATIO_W),
    .GATED   (GATED),
    .LOCK_BIT(LOCK_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .ce_out    (ce_out),
    .ref_pass_o(ref_pass_o),
    .dom_rst_o (dom_rst_o),
    .tick      (tick),
    .act_ratio (act_ratio)
);

// File: tb/sim_refdiv_ctrl.sv
module sim_refdiv_ctrl;
    import refdiv_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        we [2];
    logic [31:0] wd [2];
    logic [31:0] rd [2];
    logic        ce [2];
    logic        bp [2];
    logic        dr [2];

    always #10 clk = ~clk;

    refdiv_ctrl #(.RATIO_W(8), .GATED(1'b1), .SKIP_MODE(SKIP_NONE), .LOCK_ALT(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(we[0]), .wr_data(wd[0]), .rd_data(rd[0]),
        .ce_out(ce[0]), .ref_pass_o(bp[0]), .dom_rst_o(dr[0]));

    refdiv_ctrl #(.RATIO_W(8), .GATED(1'b0), .SKIP_MODE(SKIP_LOW3), .LOCK_ALT(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(we[1]), .wr_data(wd[1]), .rd_data(rd[1]),
        .ce_out(ce[1]), .ref_pass_o(bp[1]), .dom_rst_o(dr[1]));

    int m_en [2], m_rst [2], m_gate [2], m_stg [2], m_act [2], m_cnt [2], m_lock [2];
    int cfg_g [2]  = '{1, 0};
    int cfg_sk [2] = '{0, 2};
    int cfg_lk [2] = '{31, 27};
    int checks = 0, fails = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    function automatic int per(int a);
        return (a < 2) ? 1 : a;
    endfunction

    function automatic int remap(int i, int r);
        if (cfg_sk[i] == 1 && r == 1) return 0;
        if (cfg_sk[i] == 2 && (r == 1 || r == 2)) return 0;
        if (cfg_sk[i] == 2 && r == 3) return 4;
        return r;
    endfunction

    function automatic bit m_tick(int i);
        return (m_cnt[i] == per(m_act[i]) - 1) && (m_rst[i] == 0);
    endfunction

    function automatic bit m_ce(int i);
        return m_tick(i) && (cfg_g[i] == 0 || m_en[i] != 0);
    endfunction

    function automatic logic [31:0] m_rd(int i);
        logic [31:0] r;
        r = '0;
        r[0] = (cfg_g[i] != 0) && (m_en[i] != 0);
        r[1] = m_rst[i] != 0;
        r[11:4] = 8'(m_stg[i]);
        r[28] = m_gate[i] != 0;
        r[cfg_lk[i]] = m_lock[i] != 0;
        return r;
    endfunction

    task automatic step(int i);
        bit t, old_rst, ap;
        int w;
        t = m_tick(i);
        old_rst = m_rst[i] != 0;
        ap = 1'b0;
        if (!rst_n) begin
            m_en[i] = 0; m_rst[i] = 0; m_gate[i] = 0; m_stg[i] = 0;
            m_act[i] = 0; m_cnt[i] = 0; m_lock[i] = 0;
            return;
        end
        if (we[i]) begin
            w = remap(i, int'(wd[i][11:4]));
            if (cfg_g[i] != 0) begin
                if (m_en[i] != 0 && w != m_stg[i]) m_en[i] = 0;
                else begin m_en[i] = int'(wd[i][0]); m_stg[i] = w; end
            end else m_stg[i] = w;
            m_rst[i] = int'(wd[i][1]);
            m_gate[i] = int'(wd[i][28]);
            ap = wd[i][2];
        end
        if (ap) begin m_act[i] = m_stg[i]; m_cnt[i] = 0; m_lock[i] = 0; end
        else if (old_rst) begin m_cnt[i] = 0; m_lock[i] = 0; end
        else if (t) begin m_cnt[i] = 0; m_lock[i] = 1; end
        else m_cnt[i] = m_cnt[i] + 1;
    endtask

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        step(0);
        step(1);
        @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            chk(cur_req, $sformatf("u%0d ce", i), 32'(ce[i]), 32'(m_ce(i)));
            chk(cur_req, $sformatf("u%0d rd", i), rd[i], m_rd(i));
            chk(cur_req, $sformatf("u%0d pass", i), 32'(bp[i]), 32'(m_gate[i] == 0));
            chk(cur_req, $sformatf("u%0d drst", i), 32'(dr[i]), 32'(m_rst[i] != 0));
        end
    endtask

    task automatic wr(int i, logic [31:0] d);
        we[i] = 1'b1;
        wd[i] = d;
        cyc();
        we[i] = 1'b0;
        wd[i] = '0;
    endtask

    task automatic run(int i, int n, output int pulses);
        pulses = 0;
        for (int k = 0; k < n; k++) begin
            cyc();
            if (ce[i]) pulses++;
        end
    endtask

    function automatic logic [31:0] rw(int r);
        return 32'(r) << 4;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n, p;
        rst_n = 1'b0;
        we[0] = 1'b0; we[1] = 1'b0; wd[0] = '0; wd[1] = '0;
        repeat (3) cyc();
        chk("R1", "u0 rd in reset", rd[0], 32'h0);
        chk("R1", "u0 pass in reset", 32'(bp[0]), 32'd1);
        chk("R1", "u0 drst in reset", 32'(dr[0]), 32'd0);
        rst_n = 1'b1;
        cyc();
        chk("R1", "u0 lock after reset", 32'(rd[0][31]), 32'd1);

        cur_req = "R2";
        wr(0, rw(5));
        chk("R2", "ratio readback", 32'(rd[0][11:4]), 32'd5);

        cur_req = "R3";
        wr(0, rw(5) | 32'h4);
        chk("R3", "apply reads 0", 32'(rd[0][2]), 32'd0);
        chk("R6", "lock low after apply", 32'(rd[0][31]), 32'd0);
        cur_req = "R6";
        n = 0;
        while (!rd[0][31] && n < 40) begin cyc(); n++; end
        chk("R6", "lock latency", 32'(n), 32'd5);
        chk("R6", "within 4x ratio", 32'(n <= 20), 32'd1);

        cur_req = "R5";
        wr(0, rw(5) | 32'h1);
        run(0, 20, p);
        chk("R5", "pulses in 20 at ratio 5", 32'(p), 32'd4);

        cur_req = "R10";
        wr(0, rw(7) | 32'h1);
        chk("R10", "enable cleared", 32'(rd[0][0]), 32'd0);
        chk("R10", "ratio held", 32'(rd[0][11:4]), 32'd5);
        run(0, 10, p);
        chk("R10", "no pulses while disabled", 32'(p), 32'd0);

        cur_req = "R4";
        wr(0, rw(0) | 32'h4);
        wr(0, rw(0) | 32'h1);
        run(0, 6, p);
        chk("R4", "ratio 0 every cycle", 32'(p), 32'd6);
        wr(0, rw(1));
        wr(0, rw(1) | 32'h4);
        wr(0, rw(1) | 32'h1);
        run(0, 6, p);
        chk("R4", "ratio 1 every cycle", 32'(p), 32'd6);

        cur_req = "R13";
        wr(0, rw(3));
        wr(0, rw(3) | 32'h4);
        wr(0, rw(3) | 32'h1);
        n = 0;
        while (!ce[0] && n < 10) begin cyc(); n++; end
        wr(0, rw(3) | 32'h5);
        chk("R13", "lock low on wrap+apply", 32'(rd[0][31]), 32'd0);
        chk("R13", "no pulse after restart", 32'(ce[0]), 32'd0);
        n = 0;
        while (!ce[0] && n < 10) begin cyc(); n++; end
        chk("R13", "cycles to next pulse", 32'(n), 32'd2);

        cur_req = "R9";
        wr(0, rw(3) | 32'h3);
        chk("R9", "domain reset out", 32'(dr[0]), 32'd1);
        run(0, 5, p);
        chk("R9", "no pulses in reset", 32'(p), 32'd0);
        chk("R9", "lock cleared", 32'(rd[0][31]), 32'd0);
        wr(0, rw(3) | 32'h1);
        run(0, 6, p);

        cur_req = "R8";
        wr(0, rw(3) | 32'h1 | (32'd1 << 28));
        chk("R8", "buffer gated", 32'(bp[0]), 32'd0);
        wr(0, rw(3) | 32'h1);
        chk("R8", "buffer passed", 32'(bp[0]), 32'd1);

        cur_req = "R11";
        wr(1, rw(6) | 32'h5);
        chk("R11", "enable reads 0", 32'(rd[1][0]), 32'd0);
        run(1, 12, p);
        chk("R11", "pulses at ratio 6", 32'(p), 32'd2);
        wr(1, rw(9));
        run(1, 18, p);
        chk("R11", "old ratio until apply", 32'(p), 32'd3);
        wr(1, rw(9) | 32'h4);
        run(1, 18, p);
        chk("R11", "new ratio after apply", 32'(p), 32'd2);

        cur_req = "R7";
        chk("R7", "lock at bit 27", 32'(rd[1][27]), 32'd1);
        chk("R7", "bit 31 clear", 32'(rd[1][31]), 32'd0);

        cur_req = "R12";
        wr(1, rw(1));
        chk("R12", "1 stored as 0", 32'(rd[1][11:4]), 32'd0);
        wr(1, rw(2));
        chk("R12", "2 stored as 0", 32'(rd[1][11:4]), 32'd0);
        wr(1, rw(3));
        chk("R12", "3 stored as 4", 32'(rd[1][11:4]), 32'd4);
        wr(1, rw(5));
        chk("R12", "5 unchanged", 32'(rd[1][11:4]), 32'd5);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule